// File: doc/BRIEF.md
# Nested Exception Escalation Unit

This unit sits in a CPU core between the logic that raises exceptions and the logic that delivers them. Each request carries an exception vector and a flag marking it as a software interrupt instruction. For a checked exception (any request without that flag), the unit compares the new vector's class with the class of the exception already being delivered. From that comparison it does one of three things:

- passes the vector through unchanged,
- promotes it to a double fault (vector 8) with a forced zero error code,
- declares a triple fault. A triple fault raises a shutdown request, or a guest exit request when the core runs in guest mode.

Requests enter on a valid/ready stream and results leave on a valid/ready stream one cycle later. The unit holds at most one result. While that result waits (`out_valid` high, `out_ready` low), `in_ready` is low, no request is taken, and every output field holds its value. A result register that is empty, or one that is being drained in the same cycle, accepts a new request. `guest_mode` and `deliver_done` are plain level controls.

`deliver_done` tells the unit that the handler for the in-flight exception has been entered. It returns the unit's memory of the previous exception to idle.

Top module: `exc_escalate`

## Requirements
- R1: When the remembered exception is contributory (vector 0 or 10 to 13) and a checked contributory vector arrives, the result is vector 8 with `out_err_zero`=1 and `out_err_valid`=1.
- R2: When the remembered exception is a page fault (vector 14) and a checked contributory vector or another page fault arrives, the result is vector 8 with `out_err_zero`=1.
- R3: When the remembered exception is vector 8, any checked request produces a triple fault. The result carries vector 8 with `out_shutdown`=1 (outside guest mode), `out_err_valid`=0 and `out_err_zero`=0. The memory keeps vector 8.
- R4: A triple fault in guest mode gives `out_guest_exit`=1 and `out_shutdown`=0.
- R5: The memory takes the result vector only when that result is contributory, a page fault or vector 8. Any other result leaves the memory unchanged.
- R6: A software interrupt request is delivered with its own vector. It has `out_err_valid`=0 and `out_err_zero`=0, never signals shutdown or guest exit, and leaves the memory unchanged, even when vector 8 is remembered.
- R7: `deliver_done` returns the memory to idle, where it matches no class. A request accepted in the same cycle is judged against the idle memory, and its own memory update still takes place.
- R8: `in_ready` = not `out_valid`, or `out_ready`. A request accepted at a clock edge appears on the outputs from that edge on. While `out_valid`=1 and `out_ready`=0, all outputs hold.
- R9: For checked results that are not triple faults, `out_err_valid` is 1 exactly when the delivered vector is 8, 10 to 14, or 17. A vector such as 3 gives 0.
- R10: After reset, `out_valid`=0, `in_ready`=1 and the memory is idle, so the first contributory vector is delivered unchanged.
- R11: A page fault arriving while a contributory exception is remembered is delivered unchanged as vector 14 and becomes the remembered exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit takes the request this cycle |
| in_vector | input | 8 | Requested exception vector |
| in_swint | input | 1 | Request comes from a software interrupt instruction |
| guest_mode | input | 1 | Core runs as a guest |
| deliver_done | input | 1 | In-flight exception handed to its handler; clears memory |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vector | output | 8 | Final vector |
| out_err_valid | output | 1 | Result pushes an error code |
| out_err_zero | output | 1 | Error code must be replaced by zero |
| out_shutdown | output | 1 | Triple fault: request system shutdown |
| out_guest_exit | output | 1 | Triple fault in guest mode: request shutdown-type guest exit |

## Verification
The properties assume that every input is at a known level on each clock edge. They also assume that `guest_mode` is valid in the cycle a request is accepted. Nothing is assumed about `in_valid` staying high during back-pressure, because the unit only latches on an accepted transfer. The bench changes inputs on the falling edge only, pulses `deliver_done` alone to start each scenario from an idle memory, and uses it together with a request in one scenario to check the ordering rule.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;

  localparam int VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;

  // architectural vector numbers the escalation rules depend on
  localparam vec_t V_DIVIDE     = vec_t'(0);
  localparam vec_t V_DOUBLE     = vec_t'(8);
  localparam vec_t V_CONTRIB_LO = vec_t'(10);
  localparam vec_t V_CONTRIB_HI = vec_t'(13);
  localparam vec_t V_PAGE       = vec_t'(14);
  localparam vec_t V_ALIGN      = vec_t'(17);

  typedef enum logic [1:0] {
    RES_PASS,
    RES_DOUBLE,
    RES_TRIPLE,
    RES_SOFT
  } res_kind_e;

  typedef struct packed {
    vec_t vec;
    logic err_valid;
    logic err_zero;
    logic shutdown;
    logic guest_exit;
  } result_t;

  function automatic logic f_contrib(input vec_t v);
    return (v == V_DIVIDE) || ((v >= V_CONTRIB_LO) && (v <= V_CONTRIB_HI));
  endfunction

  function automatic logic f_has_err(input vec_t v);
    return (v == V_DOUBLE) || ((v >= V_CONTRIB_LO) && (v <= V_PAGE)) || (v == V_ALIGN);
  endfunction

endpackage

// File: rtl/exc_esc_classify.sv
module exc_esc_classify
  import exc_esc_pkg::*;
(
  input  vec_t vec,
  output logic is_contrib,
  output logic is_page,
  output logic is_double
);

  always_comb begin
    is_contrib = f_contrib(vec);
    is_page    = (vec == V_PAGE);
    is_double  = (vec == V_DOUBLE);
  end

endmodule

// File: rtl/exc_esc_history.sv
module exc_esc_history
  import exc_esc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic wr_en,
  input  vec_t wr_vec,
  output logic eff_valid,
  output vec_t eff_vec
);

  logic q_valid;
  vec_t q_vec;

  // a write of the same cycle wins over the clear (R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_vec   <= '0;
    end else if (wr_en) begin
      q_valid <= 1'b1;
      q_vec   <= wr_vec;
    end else if (clear) begin
      q_valid <= 1'b0;
      q_vec   <= '0;
    end
  end

  // a clear in this cycle is already visible to the request being judged
  always_comb begin
    eff_valid = q_valid && !clear;
    eff_vec   = clear ? '0 : q_vec;
  end

  AST_HIST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear && !wr_en |=> !q_valid); // R7

  AST_HIST_KEEP: assert property (@(posedge clk) disable iff (rst)
    !clear && !wr_en |=> $stable(q_valid) && $stable(q_vec)); // R5

endmodule

// File: rtl/exc_esc_decide.sv
module exc_esc_decide
  import exc_esc_pkg::*;
(
  input  logic    hist_valid,
  input  vec_t    hist_vec,
  input  vec_t    new_vec,
  input  logic    swint,
  input  logic    guest,
  output result_t res,
  output logic    hist_we
);

  logic hc_raw, hp_raw, hd_raw;
  logic nc, np, nd;
  logic h_contrib, h_page, h_double, escalate;
  res_kind_e kind;

  exc_esc_classify u_hist_cls (
    .vec        (hist_vec),
    .is_contrib (hc_raw),
    .is_page    (hp_raw),
    .is_double  (hd_raw)
  );

  exc_esc_classify u_new_cls (
    .vec        (new_vec),
    .is_contrib (nc),
    .is_page    (np),
    .is_double  (nd)
  );

  always_comb begin
    h_contrib = hist_valid && hc_raw;
    h_page    = hist_valid && hp_raw;
    h_double  = hist_valid && hd_raw;
    // R1 contributory pair, R2 page fault followed by contributory or page fault;
    // R11 contributory followed by page fault is not escalated
    escalate  = (h_contrib && nc) || (h_page && (nc || np));

    if (swint)         kind = RES_SOFT;
    else if (h_double) kind = RES_TRIPLE;
    else if (escalate) kind = RES_DOUBLE;
    else               kind = RES_PASS;
  end

  always_comb begin
    res     = '0;
    hist_we = 1'b0;
    unique case (kind)
      RES_SOFT: begin
        res.vec = new_vec;             // R6
      end
      RES_TRIPLE: begin
        res.vec        = V_DOUBLE;     // R3
        res.shutdown   = !guest;
        res.guest_exit = guest;        // R4
      end
      RES_DOUBLE: begin
        res.vec       = V_DOUBLE;
        res.err_valid = 1'b1;
        res.err_zero  = 1'b1;
        hist_we       = 1'b1;          // R5
      end
      default: begin
        res.vec       = new_vec;
        res.err_valid = f_has_err(new_vec); // R9
        hist_we       = nc || np || nd;     // R5
      end
    endcase
  end

endmodule

// File: rtl/exc_esc_stage.sv
module exc_esc_stage
  import exc_esc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  output logic    in_ready,
  input  result_t d,
  output logic    out_valid,
  input  logic    out_ready,
  output result_t q
);

  logic fire;

  always_comb begin
    in_ready = !out_valid || out_ready;
    fire     = in_valid && in_ready;
  end

  // R10: empty after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(q)); // R8

  AST_TAKE_LATCH: assert property (@(posedge clk) disable iff (rst)
    in_valid && (!out_valid || out_ready) |=> out_valid && (q == $past(d))); // R8

endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_esc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_vector,
  input  logic             in_swint,
  input  logic             guest_mode,
  input  logic             deliver_done,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vector,
  output logic             out_err_valid,
  output logic             out_err_zero,
  output logic             out_shutdown,
  output logic             out_guest_exit
);

  logic    h_valid;
  vec_t    h_vec;
  result_t dec_res;
  result_t stg_q;
  logic    dec_we;
  logic    fire;

  assign fire = in_valid && in_ready;

  exc_esc_history u_hist (
    .clk       (clk),
    .rst       (rst),
    .clear     (deliver_done),
    .wr_en     (fire && dec_we),
    .wr_vec    (dec_res.vec),
    .eff_valid (h_valid),
    .eff_vec   (h_vec)
  );

  exc_esc_decide u_dec (
    .hist_valid (h_valid),
    .hist_vec   (h_vec),
    .new_vec    (in_vector),
    .swint      (in_swint),
    .guest      (guest_mode),
    .res        (dec_res),
    .hist_we    (dec_we)
  );

  exc_esc_stage u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (dec_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (stg_q)
  );

  always_comb begin
    out_vector     = stg_q.vec;
    out_err_valid  = stg_q.err_valid;
    out_err_zero   = stg_q.err_zero;
    out_shutdown   = out_valid && stg_q.shutdown;
    out_guest_exit = out_valid && stg_q.guest_exit;
  end

  AST_CONTRIB_PAIR: assert property (@(posedge clk) disable iff (rst)
    fire && !in_swint && h_valid && f_contrib(h_vec) && f_contrib(in_vector)
    |=> out_valid && (out_vector == V_DOUBLE) && out_err_zero); // R1

  AST_PAGE_ESC: assert property (@(posedge clk) disable iff (rst)
    fire && !in_swint && h_valid && (h_vec == V_PAGE) &&
    (f_contrib(in_vector) || (in_vector == V_PAGE))
    |=> out_valid && (out_vector == V_DOUBLE) && out_err_zero); // R2

  AST_TRIPLE_SHUT: assert property (@(posedge clk) disable iff (rst)
    fire && !in_swint && !guest_mode && h_valid && (h_vec == V_DOUBLE)
    |=> out_shutdown && !out_guest_exit && !out_err_valid); // R3

  AST_TRIPLE_GUEST: assert property (@(posedge clk) disable iff (rst)
    fire && !in_swint && guest_mode && h_valid && (h_vec == V_DOUBLE)
    |=> out_guest_exit && !out_shutdown); // R4

  AST_SOFT_PASS: assert property (@(posedge clk) disable iff (rst)
    fire && in_swint
    |=> (out_vector == $past(in_vector)) && !out_err_valid && !out_err_zero &&
        !out_shutdown && !out_guest_exit); // R6

endmodule

// File: tb/exc_escalate_tb.sv
module exc_escalate_tb;
  import exc_esc_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_swint = 1'b0, guest_mode = 1'b0, deliver_done = 1'b0;
  logic out_ready = 1'b1;
  logic [VEC_W-1:0] in_vector = '0;
  logic in_ready, out_valid, out_err_valid, out_err_zero, out_shutdown, out_guest_exit;
  logic [VEC_W-1:0] out_vector;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_escalate u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_vector(in_vector),
    .in_swint(in_swint), .guest_mode(guest_mode), .deliver_done(deliver_done),
    .out_valid(out_valid), .out_ready(out_ready), .out_vector(out_vector),
    .out_err_valid(out_err_valid), .out_err_zero(out_err_zero),
    .out_shutdown(out_shutdown), .out_guest_exit(out_guest_exit)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // compares valid, vector, err_valid, err_zero, shutdown, guest_exit
  task automatic expect_out(input string tag, input int v, input bit ev, input bit ez,
                            input bit sd, input bit ge);
    logic [12:0] act, exp;
    act = {out_valid, out_vector, out_err_valid, out_err_zero, out_shutdown, out_guest_exit};
    exp = {1'b1, VEC_W'(v), ev, ez, sd, ge};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual v=%0b vec=%0d ev=%0b ez=%0b sd=%0b ge=%0b expected v=1 vec=%0d ev=%0b ez=%0b sd=%0b ge=%0b",
               tag, out_valid, out_vector, out_err_valid, out_err_zero, out_shutdown,
               out_guest_exit, v, ev, ez, sd, ge);
    end
  endtask

  // one accepted request; returns at the falling edge after the accepting edge
  task automatic send(input int v, input bit sw, input bit g, input bit d);
    @(negedge clk);
    in_valid = 1'b1; in_vector = VEC_W'(v); in_swint = sw; guest_mode = g; deliver_done = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; deliver_done = 1'b0; in_swint = 1'b0;
  endtask

  task automatic clear_hist();
    @(negedge clk);
    deliver_done = 1'b1;
    @(negedge clk);
    deliver_done = 1'b0;
  endtask

  task automatic t_reset();
    check_bit("R10 out_valid after reset", out_valid, 1'b0);
    check_bit("R10 in_ready after reset", in_ready, 1'b1);
    send(13, 0, 0, 0);
    expect_out("R10 first contributory passes", 13, 1, 0, 0, 0);
  endtask

  task automatic t_contrib_pair();
    clear_hist();
    send(13, 0, 0, 0);
    send(10, 0, 0, 0);
    expect_out("R1 13 then 10", 8, 1, 1, 0, 0);
    clear_hist();
    send(0, 0, 0, 0);
    expect_out("R9 vector 0 has no error code", 0, 0, 0, 0, 0);
    send(12, 0, 0, 0);
    expect_out("R1 0 then 12", 8, 1, 1, 0, 0);
  endtask

  task automatic t_page();
    clear_hist();
    send(14, 0, 0, 0);
    expect_out("R9 page fault error code", 14, 1, 0, 0, 0);
    send(14, 0, 0, 0);
    expect_out("R2 page then page", 8, 1, 1, 0, 0);
    clear_hist();
    send(14, 0, 0, 0);
    send(0, 0, 0, 0);
    expect_out("R2 page then contributory", 8, 1, 1, 0, 0);
  endtask

  task automatic t_contrib_then_page();
    clear_hist();
    send(11, 0, 0, 0);
    send(14, 0, 0, 0);
    expect_out("R11 page after contributory passes", 14, 1, 0, 0, 0);
    send(13, 0, 0, 0);
    expect_out("R11 page now remembered", 8, 1, 1, 0, 0);
  endtask

  task automatic t_benign();
    clear_hist();
    send(12, 0, 0, 0);
    send(3, 0, 0, 0);
    expect_out("R9 benign vector 3", 3, 0, 0, 0, 0);
    send(10, 0, 0, 0);
    expect_out("R5 benign left memory contributory", 8, 1, 1, 0, 0);
    clear_hist();
    send(17, 0, 0, 0);
    expect_out("R9 vector 17 error code", 17, 1, 0, 0, 0);
    send(11, 0, 0, 0);
    expect_out("R5 vector 17 not remembered", 11, 1, 0, 0, 0);
  endtask

  task automatic t_triple();
    clear_hist();
    send(10, 0, 0, 0);
    send(11, 0, 0, 0);
    send(5, 0, 0, 0);
    expect_out("R3 triple fault shutdown", 8, 0, 0, 1, 0);
    send(14, 0, 1, 0);
    expect_out("R4 triple fault guest exit", 8, 0, 0, 0, 1);
  endtask

  task automatic t_swint();
    clear_hist();
    send(14, 0, 0, 0);
    send(14, 1, 0, 0);
    expect_out("R6 soft interrupt passes after page", 14, 0, 0, 0, 0);
    send(3, 0, 0, 0);
    send(0, 0, 0, 0);
    expect_out("R6 memory still page fault", 8, 1, 1, 0, 0);
    send(5, 1, 0, 0);
    expect_out("R6 soft interrupt passes over double", 5, 0, 0, 0, 0);
  endtask

  task automatic t_done();
    clear_hist();
    send(10, 0, 0, 0);
    clear_hist();
    send(11, 0, 0, 0);
    expect_out("R7 clear alone", 11, 1, 0, 0, 0);
    send(12, 0, 0, 1);
    expect_out("R7 clear with request", 12, 1, 0, 0, 0);
    send(13, 0, 0, 0);
    expect_out("R7 same-cycle write kept", 8, 1, 1, 0, 0);
  endtask

  task automatic t_backpressure();
    clear_hist();
    @(negedge clk);
    out_ready = 1'b0;
    send(10, 0, 0, 0);
    expect_out("R8 first result", 10, 1, 0, 0, 0);
    in_valid = 1'b1; in_vector = VEC_W'(11); in_swint = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R8 in_ready low while stalled", in_ready, 1'b0);
    expect_out("R8 result held", 10, 1, 0, 0, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R8 next taken on drain", 8, 1, 1, 0, 0);
    @(negedge clk);
    check_bit("R8 empty after drain", out_valid, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_contrib_pair();
    t_page();
    t_contrib_then_page();
    t_benign();
    t_triple();
    t_swint();
    t_done();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL R8 watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule